// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

The block is a register of `WIDTH` bits, eight by default. On each rising clock edge it does one of four things, picked by a two-bit select: it keeps its value, shifts toward the high end, shifts toward the low end, or takes a new word from a parallel bus. The same parallel bus carries the load data in and the register contents out. Inside the chip the bus is split into three signals: an input word, an output word that always shows the register contents, and a drive enable. Logic around the block uses these to build the real shared bus.

The drive enable is high only when both disable inputs are low and load mode is not selected. This keeps the bus free for incoming data during a load. The end bits of the register appear on two dedicated serial outputs that the disable inputs do not affect. Several registers can be chained into a longer shifter by linking each register's end outputs to its neighbour's serial inputs. An active-low asynchronous reset clears the register at once.

The select code decodes to four named modes: MODE_HOLD, MODE_SHR, MODE_SHL and MODE_LOAD. Any mode can follow any other on the next clock edge. The only other change of state is reset, which goes to all-zero from any mode.

Top module: `ushift_bus_reg`

## Requirements
- R1: While `rst_n` is low, the register is zero and `bus_out` reads 0, whatever the clock, select and data inputs are doing. No clock edge is needed.
- R2: With `sel` = 2'b00 (hold), a rising edge leaves the register unchanged.
- R3: With `sel` = 2'b01 (shift right), a rising edge loads `ser_r_in` into bit 0 and moves each bit n into bit n+1.
- R4: With `sel` = 2'b10 (shift left), a rising edge loads `ser_l_in` into bit WIDTH-1 and moves each bit n into bit n-1.
- R5: With `sel` = 2'b11 (load), a rising edge copies `bus_in` bit n into register bit n.
- R6: `bus_oe` is low whenever `dis_a` or `dis_b` is high.
- R7: `bus_oe` is low whenever `sel` = 2'b11, and is high when neither disable is set and `sel` is not 2'b11.
- R8: Hold, shift, load and reset work the same while the bus drive is disabled.
- R9: `ser_lo_out` always equals register bit 0 and `ser_hi_out` always equals bit WIDTH-1, whatever the disable inputs are.
- R10: `bus_out` always shows the current register contents. Apart from reset, it changes only after a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Mode select: 00 hold, 01 shift right, 10 shift left, 11 load |
| ser_r_in | input | 1 | Serial bit entering bit 0 on a right shift |
| ser_l_in | input | 1 | Serial bit entering bit WIDTH-1 on a left shift |
| dis_a | input | 1 | Bus drive disable, active high |
| dis_b | input | 1 | Bus drive disable, active high |
| bus_in | input | WIDTH | Bus value sampled in load mode |
| bus_out | output | WIDTH | Register contents presented to the bus |
| bus_oe | output | 1 | Bus drive enable |
| ser_lo_out | output | 1 | Register bit 0 |
| ser_hi_out | output | 1 | Register bit WIDTH-1 |

## Verification
The bench builds one instance at the default width of 8. It also builds two more 8-bit instances chained through their serial ports into a 16-bit shifter. This chain shows that bits cross the link correctly in both directions, and that both drive enables drop during a load. The single instance receives random select, serial, disable and bus values. It also gets directed cases: a load while the bus is disabled, a reset in the middle of a cycle, and walking bits through both ends.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } mode_t;

    typedef struct packed {
        logic hold;
        logic shr;
        logic shl;
        logic load;
    } mode_oh_t;

endpackage

// File: rtl/ushift_mode_dec.sv
module ushift_mode_dec
    import ushift_pkg::*;
(
    input  logic [1:0] sel,
    output mode_oh_t   oh
);

    always_comb begin
        oh = '0;
        unique case (mode_t'(sel))
            MODE_HOLD: oh.hold = 1'b1;
            MODE_SHR:  oh.shr  = 1'b1;
            MODE_SHL:  oh.shl  = 1'b1;
            MODE_LOAD: oh.load = 1'b1;
        endcase
    end

endmodule

// File: rtl/ushift_core.sv
module ushift_core
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_oh_t         oh,
    input  logic             ser_r_in,
    input  logic             ser_l_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] q_nxt;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic from_lo;
        logic from_hi;

        if (g == 0) begin : g_lo_end
            assign from_lo = ser_r_in;
        end else begin : g_lo_mid
            assign from_lo = q[g-1];
        end

        if (g == TOP) begin : g_hi_end
            assign from_hi = ser_l_in;
        end else begin : g_hi_mid
            assign from_hi = q[g+1];
        end

        always_comb begin
            if (oh.hold)      q_nxt[g] = q[g];
            else if (oh.load) q_nxt[g] = par_in[g];
            else if (oh.shr)  q_nxt[g] = from_lo;
            else if (oh.shl)  q_nxt[g] = from_hi;
            else              q_nxt[g] = q[g];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= q_nxt;
    end

endmodule

// File: rtl/ushift_bus_ctl.sv
module ushift_bus_ctl (
    input  logic load_sel,
    input  logic dis_a,
    input  logic dis_b,
    output logic bus_oe
);

    always_comb begin
        bus_oe = !(dis_a || dis_b) && !load_sel;
    end

endmodule

// File: rtl/ushift_bus_reg.sv
module ushift_bus_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic             ser_r_in,
    input  logic             ser_l_in,
    input  logic             dis_a,
    input  logic             dis_b,
    input  logic [WIDTH-1:0] bus_in,
    output logic [WIDTH-1:0] bus_out,
    output logic             bus_oe,
    output logic             ser_lo_out,
    output logic             ser_hi_out
);

    localparam int TOP = WIDTH - 1;

    mode_oh_t         oh;
    logic [WIDTH-1:0] q;

    ushift_mode_dec u_dec (
        .sel (sel),
        .oh  (oh)
    );

    ushift_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .oh       (oh),
        .ser_r_in (ser_r_in),
        .ser_l_in (ser_l_in),
        .par_in   (bus_in),
        .q        (q)
    );

    ushift_bus_ctl u_ctl (
        .load_sel (oh.load),
        .dis_a    (dis_a),
        .dis_b    (dis_b),
        .bus_oe   (bus_oe)
    );

    assign bus_out    = q;
    assign ser_lo_out = q[0];
    assign ser_hi_out = q[TOP];

endmodule

// File: rtl/ushift_chk.sv
module ushift_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       sel,
    input logic             ser_r_in,
    input logic             ser_l_in,
    input logic             dis_a,
    input logic             dis_b,
    input logic [WIDTH-1:0] bus_in,
    input logic [WIDTH-1:0] bus_out,
    input logic             bus_oe,
    input logic             ser_lo_out,
    input logic             ser_hi_out
);

    // R2
    hold_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 2'b00 |=> $stable(bus_out));

    // R3
    shr_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 2'b01 |=> bus_out == {$past(bus_out[WIDTH-2:0]), $past(ser_r_in)});

    // R4
    shl_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 2'b10 |=> bus_out == {$past(ser_l_in), $past(bus_out[WIDTH-1:1])});

    // R5
    load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 2'b11 |=> bus_out == $past(bus_in));

    // R6
    dis_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_a || dis_b) |-> !bus_oe);

    // R7
    load_frees_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel == 2'b11 |-> !bus_oe);

    // R9
    ends_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_lo_out == bus_out[0] && ser_hi_out == bus_out[WIDTH-1]);

endmodule

bind ushift_bus_reg ushift_chk #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .ser_r_in   (ser_r_in),
    .ser_l_in   (ser_l_in),
    .dis_a      (dis_a),
    .dis_b      (dis_b),
    .bus_in     (bus_in),
    .bus_out    (bus_out),
    .bus_oe     (bus_oe),
    .ser_lo_out (ser_lo_out),
    .ser_hi_out (ser_hi_out)
);

// File: tb/sim_ushift_bus_reg.sv
module sim_ushift_bus_reg;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // single instance
    logic       rst_n = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       sr = 1'b0, sl = 1'b0, da = 1'b0, db = 1'b0;
    logic [7:0] bin = '0;
    logic [7:0] bout;
    logic       boe, slo, shi;

    ushift_bus_reg #(.WIDTH(8)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ser_r_in(sr), .ser_l_in(sl),
        .dis_a(da), .dis_b(db), .bus_in(bin), .bus_out(bout), .bus_oe(boe),
        .ser_lo_out(slo), .ser_hi_out(shi)
    );

    // 16-bit chain of two instances
    logic        c_sr = 1'b0, c_sl = 1'b0;
    logic [15:0] c_bin = '0;
    logic [7:0]  lo_out, hi_out;
    logic        lo_oe, hi_oe, lo_lo, lo_hi, hi_lo, hi_hi;

    ushift_bus_reg #(.WIDTH(8)) u_lo (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ser_r_in(c_sr), .ser_l_in(hi_lo),
        .dis_a(1'b0), .dis_b(1'b0), .bus_in(c_bin[7:0]), .bus_out(lo_out),
        .bus_oe(lo_oe), .ser_lo_out(lo_lo), .ser_hi_out(lo_hi)
    );

    ushift_bus_reg #(.WIDTH(8)) u_hi (
        .clk(clk), .rst_n(rst_n), .sel(sel), .ser_r_in(lo_hi), .ser_l_in(c_sl),
        .dis_a(1'b0), .dis_b(1'b0), .bus_in(c_bin[15:8]), .bus_out(hi_out),
        .bus_oe(hi_oe), .ser_lo_out(hi_lo), .ser_hi_out(hi_hi)
    );

    logic [7:0]  m8 = '0;
    logic [15:0] m16 = '0;

    function automatic logic [7:0] nxt8(logic [7:0] q, logic [1:0] s,
                                        logic r, logic l, logic [7:0] d);
        case (s)
            2'b00:   return q;
            2'b01:   return {q[6:0], r};
            2'b10:   return {l, q[7:1]};
            default: return d;
        endcase
    endfunction

    function automatic logic [15:0] nxt16(logic [15:0] q, logic [1:0] s,
                                          logic r, logic l, logic [15:0] d);
        case (s)
            2'b00:   return q;
            2'b01:   return {q[14:0], r};
            2'b10:   return {l, q[15:1]};
            default: return d;
        endcase
    endfunction

    function automatic string tag_of(logic [1:0] s);
        case (s)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Inputs change at the falling edge; outputs are sampled 1 ns later,
    // then the register state is sampled at the next falling edge.
    task automatic step(logic [1:0] s, logic r, logic l, logic a, logic b,
                        logic [7:0] d, logic cr, logic cl, logic [15:0] cd);
        logic exp_oe;
        sel = s; sr = r; sl = l; da = a; db = b; bin = d;
        c_sr = cr; c_sl = cl; c_bin = cd;
        #1;
        exp_oe = !(a || b) && (s != 2'b11);
        // R6 R7
        chk(boe == exp_oe, (a || b) ? "R6" : "R7", {15'd0, boe}, {15'd0, exp_oe});
        // R7: both chained drivers released during load
        chk(lo_oe == (s != 2'b11) && hi_oe == (s != 2'b11), "R7",
            {14'd0, hi_oe, lo_oe}, {14'd0, {2{s != 2'b11}}});
        @(posedge clk);
        m8  = nxt8(m8, s, r, l, d);
        m16 = nxt16(m16, s, cr, cl, cd);
        @(negedge clk);
        // R8 covered when a or b set; R10 via bus_out
        chk(bout == m8, (a || b) ? "R8" : tag_of(s), {8'd0, bout}, {8'd0, m8});
        chk({hi_out, lo_out} == m16, tag_of(s), {hi_out, lo_out}, m16);
        // R9
        chk(slo == m8[0] && shi == m8[7], "R9", {14'd0, shi, slo}, {14'd0, m8[7], m8[0]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #2;
        // R1 reset state
        chk(bout == 8'h00, "R1", {8'd0, bout}, 16'h0000);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R5 load while disabled (R8, R6)
        step(2'b11, 0, 0, 1, 0, 8'hA5, 0, 0, 16'h8001);
        // R2 hold while disabled
        step(2'b00, 1, 1, 0, 1, 8'h00, 1, 1, 16'h0000);
        // R3 shift right, 20 steps through the chain link
        for (int i = 0; i < 20; i++)
            step(2'b01, i[0], 0, 0, 0, 8'h00, i[1], 0, 16'h0000);
        // R4 shift left, 20 steps
        for (int i = 0; i < 20; i++)
            step(2'b10, 0, i[0], 1, 1, 8'h00, 0, ~i[0], 16'h0000);
        // R1 asynchronous clear mid-cycle, select in load
        sel = 2'b11; bin = 8'hFF; c_bin = 16'hFFFF;
        #2;
        rst_n = 1'b0;
        #1;
        m8 = '0; m16 = '0;
        chk(bout == 8'h00, "R1", {8'd0, bout}, 16'h0000);
        chk({hi_out, lo_out} == 16'h0000, "R1", {hi_out, lo_out}, 16'h0000);
        @(posedge clk); #1;
        chk(bout == 8'h00, "R1", {8'd0, bout}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step(rv[1:0], rv[2], rv[3], rv[4] & rv[5], rv[6] & rv[7], rv[15:8],
                 rv[16], rv[17], $urandom);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule